// File: doc/BRIEF.md
# Vectored Interrupt Peripheral

This block sits on the peripheral side of a simple memory-mapped system bus. Incoming words arrive on a valid/ready stream and are captured into an input holding register. Each capture raises an interrupt request to the processor. The processor services the request in one of two ways. It can read the holding register directly, which withdraws the request. It can also raise its acknowledge line, and the block then places an interrupt vector on the read data bus. The processor loads an output register by writing to a second mapped address, and the value of that register appears on a dedicated output port.

The vector comes from a build-time choice. In full-address mode the block drives the complete service-routine address, which defaults to 16. In table mode it drives only a short index into a vector table held by the processor, so fewer bits are significant on the bus. The read data bus is modelled as a muxed bus. `bus_oe` marks the cycles in which this block drives the bus, and `bus_rdata` is zero in every other cycle.

Stream rule: `in_ready` is held high at all times, so the block never applies back-pressure. A word offered while a request is still pending is accepted anyway and overwrites the held word. The block records that loss as an overrun.

Top module: `vec_irq_periph`

## Requirements
- R1: While reset is asserted, and on leaving it, the input register, output register, `irq`, `ovf`, `bus_oe` and `bus_rdata` are all zero.
- R2: `in_ready` is always 1. When `in_valid` is high at a clock edge, `in_data` is stored and `irq` is 1 from the following cycle.
- R3: If a word is captured while `irq` is already 1, the new word replaces the held one, `irq` stays 1, and `ovf` becomes 1. Once set, `ovf` stays 1 until reset.
- R4: A read (`bus_rd`=1) at address 0x8000, when no acknowledge is being served, returns the held input word on `bus_rdata` in the same cycle with `bus_oe`=1. It clears `irq` from the next cycle, unless a new word is captured at that same edge.
- R5: A write (`bus_wr`=1) at address 0x8001 loads `bus_wdata` into the output register, which appears on `out_data` from the next cycle. A write to any other address, including 0x8000, changes neither `out_data` nor the held input word.
- R6: A read at 0x8001 returns the output register value on `bus_rdata` in the same cycle, with `bus_oe`=1.
- R7: In every cycle in which `inta`=1 and `irq`=1, `bus_oe`=1 and `bus_rdata` carries the vector. This takes priority over any read, and a read in such a cycle does not clear `irq`. In full-address mode (`TABLE_MODE`=0) the vector is `VEC_ADDR`, which defaults to 16.
- R8: In table mode (`TABLE_MODE`=1), the acknowledge vector is the table index `VEC_IDX` (default 5) in the low `IDX_W` bits, with all upper bits zero.
- R9: When there is neither an acknowledge with a pending request nor a read of a mapped address, `bus_oe`=0 and `bus_rdata`=0. In particular, `inta`=1 with no pending request drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming word valid |
| in_ready | output | 1 | Always 1; words are never refused |
| in_data | input | DW | Incoming word |
| bus_addr | input | AW | Bus address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Read data or vector; zero when not driving |
| bus_oe | output | 1 | Block is driving `bus_rdata` |
| inta | input | 1 | Interrupt acknowledge from the processor |
| irq | output | 1 | Interrupt request |
| ovf | output | 1 | Sticky overrun flag |
| out_data | output | DW | Output register contents |

## Verification
The bench targets these collisions:
- A capture and a read of the input register at the same edge. A design that let the clear win would drop a request whose word has not yet been seen.
- A read issued while an acknowledge is active. A design that served the read, or treated it as the servicing read, would put data in place of the vector or lose the request before the service routine runs.
- An acknowledge with no request pending, which must leave the bus undriven.
- A second capture before servicing, which must raise and hold the overrun flag.

Both vector modes are instantiated side by side and driven with the same stimulus.

// File: rtl/vip_pkg.sv
package vip_pkg;

  // Source selected onto the read data bus in a given cycle.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_IN   = 2'd2,
    SEL_OUT  = 2'd3
  } rd_sel_e;

endpackage

// File: rtl/vip_decode.sv
module vip_decode
  import vip_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] IN_ADDR  = 16'h8000,
  parameter logic [AW-1:0] OUT_ADDR = 16'h8001
) (
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          inta,
  input  logic          irq,
  output rd_sel_e       sel,
  output logic          rd_in_clr,
  output logic          wr_out
);

  logic hit_in;
  logic hit_out;
  logic ack_live;

  assign hit_in   = (bus_addr == IN_ADDR);
  assign hit_out  = (bus_addr == OUT_ADDR);
  assign ack_live = inta & irq;

  always_comb begin
    if (ack_live)               sel = SEL_VEC;
    else if (bus_rd && hit_in)  sel = SEL_IN;
    else if (bus_rd && hit_out) sel = SEL_OUT;
    else                        sel = SEL_NONE;
  end

  // A read issued under an active acknowledge is not a servicing read.
  assign rd_in_clr = bus_rd & hit_in & ~ack_live;
  assign wr_out    = bus_wr & hit_out;

endmodule

// File: rtl/vip_capture.sv
module vip_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  input  logic          clr,
  output logic [DW-1:0] data_q,
  output logic          irq_q,
  output logic          ovf_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (cap) begin
        data_q <= cap_data;
        irq_q  <= 1'b1;
        if (irq_q) ovf_q <= 1'b1;
      end else if (clr) begin
        irq_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vip_outreg.sv
module vip_outreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end

endmodule

// File: rtl/vip_vecgen.sv
module vip_vecgen #(
  parameter int DW         = 8,
  parameter bit TABLE_MODE = 1'b0,
  parameter int VEC_ADDR   = 16,
  parameter int IDX_W      = 3,
  parameter int VEC_IDX    = 5
) (
  output logic [DW-1:0] vec
);

  generate
    if (TABLE_MODE) begin : g_table
      localparam logic [IDX_W-1:0] IDX = IDX_W'(VEC_IDX);
      assign vec = DW'(IDX);
    end else begin : g_full
      assign vec = DW'(VEC_ADDR);
    end
  endgenerate

endmodule

// File: rtl/vec_irq_periph.sv
module vec_irq_periph
  import vip_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 16,
  parameter logic [AW-1:0] IN_ADDR  = 16'h8000,
  parameter logic [AW-1:0] OUT_ADDR = 16'h8001,
  parameter bit TABLE_MODE = 1'b0,
  parameter int VEC_ADDR   = 16,
  parameter int IDX_W      = 3,
  parameter int VEC_IDX    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_oe,
  input  logic          inta,
  output logic          irq,
  output logic          ovf,
  output logic [DW-1:0] out_data
);

  rd_sel_e       rd_sel;
  logic          rd_clr;
  logic          wr_out;
  logic [DW-1:0] in_q;
  logic [DW-1:0] vec;

  assign in_ready = 1'b1;

  vip_decode #(.AW(AW), .IN_ADDR(IN_ADDR), .OUT_ADDR(OUT_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .inta     (inta),
    .irq      (irq),
    .sel      (rd_sel),
    .rd_in_clr(rd_clr),
    .wr_out   (wr_out)
  );

  vip_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (in_valid),
    .cap_data(in_data),
    .clr     (rd_clr),
    .data_q  (in_q),
    .irq_q   (irq),
    .ovf_q   (ovf)
  );

  vip_outreg #(.DW(DW)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (wr_out),
    .wdata(bus_wdata),
    .q    (out_data)
  );

  vip_vecgen #(
    .DW(DW), .TABLE_MODE(TABLE_MODE), .VEC_ADDR(VEC_ADDR),
    .IDX_W(IDX_W), .VEC_IDX(VEC_IDX)
  ) u_vec (
    .vec(vec)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_VEC: begin bus_rdata = vec;      bus_oe = 1'b1; end
      SEL_IN:  begin bus_rdata = in_q;     bus_oe = 1'b1; end
      SEL_OUT: begin bus_rdata = out_data; bus_oe = 1'b1; end
      default: begin bus_rdata = '0;       bus_oe = 1'b0; end
    endcase
  end

endmodule

// File: rtl/vip_checker.sv
module vip_checker #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] IN_ADDR  = 16'h8000,
  parameter logic [AW-1:0] OUT_ADDR = 16'h8001
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_oe,
  input logic          inta,
  input logic          irq,
  input logic          ovf,
  input logic [DW-1:0] out_data
);

  AST_CAPTURE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> irq); // R2

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && irq) |=> ovf); // R3

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == IN_ADDR && !inta && !in_valid) |=> !irq); // R4

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OUT_ADDR) |=> $stable(out_data)); // R5

  AST_ACK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && irq) |-> bus_oe); // R7

  AST_ACK_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && irq) |=> irq); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_rdata == '0)); // R9

  AST_NO_SPURIOUS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !(inta && irq)) |-> !bus_oe); // R9

endmodule

bind vec_irq_periph vip_checker #(
  .DW(DW), .AW(AW), .IN_ADDR(IN_ADDR), .OUT_ADDR(OUT_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_rdata(bus_rdata),
  .bus_oe   (bus_oe),
  .inta     (inta),
  .irq      (irq),
  .ovf      (ovf),
  .out_data (out_data)
);

// File: tb/tb_vec_irq_periph.sv
module tb_vec_irq_periph;

  localparam int DW = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] A_IN  = 16'h8000;
  localparam logic [AW-1:0] A_OUT = 16'h8001;
  localparam logic [DW-1:0] V_FULL = 8'd16;
  localparam logic [DW-1:0] V_TBL  = 8'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          inta = 1'b0;

  logic          rdy_a, rdy_b;
  logic [DW-1:0] rdata_a, rdata_b;
  logic          oe_a, oe_b, irq_a, irq_b, ovf_a, ovf_b;
  logic [DW-1:0] out_a, out_b;

  always #4 clk = ~clk;

  vec_irq_periph dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_data(in_data), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .bus_oe(oe_a), .inta(inta),
    .irq(irq_a), .ovf(ovf_a), .out_data(out_a)
  );

  vec_irq_periph #(.TABLE_MODE(1'b1)) dut_tbl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .in_data(in_data), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .bus_oe(oe_b), .inta(inta),
    .irq(irq_b), .ovf(ovf_b), .out_data(out_b)
  );

  // Behavioural reference state
  logic [DW-1:0] m_in, m_out;
  logic          m_irq, m_ovf;
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in <= '0; m_out <= '0; m_irq <= 1'b0; m_ovf <= 1'b0;
    end else begin
      if (in_valid) begin
        m_in <= in_data;
        m_irq <= 1'b1;
        if (m_irq) m_ovf <= 1'b1;
      end else if (bus_rd && bus_addr == A_IN && !(inta && m_irq)) begin
        m_irq <= 1'b0;
      end
      if (bus_wr && bus_addr == A_OUT) m_out <= bus_wdata;
    end
  end

  function automatic logic [DW-1:0] exp_rdata(input logic [DW-1:0] vec);
    if (inta && m_irq)                return vec;
    if (bus_rd && bus_addr == A_IN)  return m_in;
    if (bus_rd && bus_addr == A_OUT) return m_out;
    return '0;
  endfunction

  function automatic logic exp_oe();
    return (inta && m_irq) || (bus_rd && (bus_addr == A_IN || bus_addr == A_OUT));
  endfunction

  task automatic cmp(input string tag, input string nm, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
    end
  endtask

  // Inputs are already set for this cycle; compare, then move to next negedge.
  task automatic chk(input string tag);
    #1;
    vectors++;
    cmp(tag, "in_ready",  DW'(rdy_a),  DW'(1'b1));
    cmp(tag, "irq",       DW'(irq_a),  DW'(m_irq));
    cmp(tag, "ovf",       DW'(ovf_a),  DW'(m_ovf));
    cmp(tag, "out_data",  out_a,       m_out);
    cmp(tag, "bus_oe",    DW'(oe_a),   DW'(exp_oe()));
    cmp(tag, "bus_rdata", rdata_a,     exp_rdata(V_FULL));
    cmp(tag, "tbl irq",   DW'(irq_b),  DW'(m_irq));
    cmp(tag, "tbl ovf",   DW'(ovf_b),  DW'(m_ovf));
    cmp(tag, "tbl out",   out_b,       m_out);
    cmp(tag, "tbl in_ready", DW'(rdy_b), DW'(1'b1));
    cmp(tag, "tbl bus_oe",  DW'(oe_b), DW'(exp_oe()));
    cmp(tag, "tbl bus_rdata", rdata_b, exp_rdata(V_TBL));
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; inta = 1'b0;
    bus_addr = '0; bus_wdata = '0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        miscompares++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin : stim
    int lfsr;
    @(negedge clk);
    idle();
    in_valid = 1'b1; in_data = 8'hEE; // ignored under reset
    chk("R1");
    chk("R1");
    idle();
    rst_n = 1'b1;
    chk("R1");

    // R2: capture raises request
    in_valid = 1'b1; in_data = 8'h3C; chk("R2");
    idle(); chk("R2");

    // R7/R8: acknowledge held for several cycles, with a read mixed in
    inta = 1'b1; chk("R7");
    chk("R8");
    bus_rd = 1'b1; bus_addr = A_IN; chk("R7");
    bus_rd = 1'b0; chk("R7");
    idle(); chk("R7");

    // R4: servicing read clears request
    bus_rd = 1'b1; bus_addr = A_IN; chk("R4");
    idle(); chk("R4");

    // R9: acknowledge with nothing pending, unmapped read
    inta = 1'b1; chk("R9");
    idle(); bus_rd = 1'b1; bus_addr = 16'h8002; chk("R9");
    idle(); chk("R9");

    // R5/R6: output register write and readback
    bus_wr = 1'b1; bus_addr = A_OUT; bus_wdata = 8'hA5; chk("R5");
    idle(); bus_rd = 1'b1; bus_addr = A_OUT; chk("R6");
    idle(); bus_wr = 1'b1; bus_addr = A_IN; bus_wdata = 8'h77; chk("R5");
    idle(); bus_wr = 1'b1; bus_addr = 16'h1234; bus_wdata = 8'h11; chk("R5");
    idle(); bus_rd = 1'b1; bus_addr = A_IN; chk("R5");
    idle(); chk("R6");

    // R3: overrun
    in_valid = 1'b1; in_data = 8'h01; chk("R3");
    in_data = 8'h02; chk("R3");
    idle(); chk("R3");
    bus_rd = 1'b1; bus_addr = A_IN; chk("R3");
    idle(); chk("R3");

    // R4: capture and servicing read at the same edge
    in_valid = 1'b1; in_data = 8'h55; bus_rd = 1'b1; bus_addr = A_IN; chk("R4");
    idle(); chk("R4");
    bus_rd = 1'b1; bus_addr = A_IN; chk("R4");
    idle(); chk("R4");

    // Mixed traffic
    lfsr = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr == 0) lfsr = 1;
      in_valid  = (lfsr[2:0] == 3'd0);
      in_data   = lfsr[15:8];
      inta      = lfsr[4] & lfsr[5];
      bus_rd    = lfsr[6];
      bus_wr    = lfsr[7] & ~lfsr[6];
      bus_wdata = lfsr[23:16];
      case (lfsr[25:24])
        2'd0: bus_addr = A_IN;
        2'd1: bus_addr = A_OUT;
        2'd2: bus_addr = 16'h8002;
        default: bus_addr = A_IN;
      endcase
      chk("R7");
    end
    idle(); chk("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule